// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register Window

This block places eight timekeeping registers at the eight highest byte addresses of a bytewide memory space. Every other address is passed through unchanged to an ordinary RAM port. Software reads and writes the registers with the same single-cycle bus transfers it uses for RAM bytes. What software sees is a user copy of the time. That copy is kept separate from the calendar counter, which the block reaches over a parallel time bus.

While both control bits are clear, the user copy tracks the counter once per second. The update happens on a cycle with no bus transfer, so software never reads a half-updated set of registers. The read bit freezes the copy so that a consistent snapshot can be read. The write bit also freezes the copy; software then loads new values into it, and clearing the bit hands those values to the counter in one transfer. In both cases the counter keeps running.

Top module: `rtc_regwin`

## Requirements
- R1: An address whose upper address bits are all ones (the top eight bytes, 0x7F8 to 0x7FF with the default 11-bit address) selects a register. Every other address drives `ram_sel` while `bus_sel` is high, and `bus_rdata` returns `ram_rdata`. `ram_sel` is never high for a register address or while `bus_sel` is low.
- R2: The register offset is the low three address bits: 0 century and control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. `bus_rdata` shows the addressed register in the same cycle, with or without `bus_sel`. A write stores `bus_wdata` at the clock edge that samples it.
- R3: While both control bits are clear, a cycle with `tick` high and `bus_sel` low updates the user copy at that edge. Each byte takes the counter-owned bits from `live_time` (byte i is bits 8i+7..8i) and keeps its other bits.
- R4: A tick that arrives while `bus_sel` is high is held. The update happens at the first following edge with `bus_sel` low, and never during a bus transfer.
- R5: While the read bit (bit 6 of register 0) is 1, ticks do not change the user copy. The copy keeps the values it held when the bit was set.
- R6: After the read bit is written back to 0, the copy stays unchanged until the next tick. The whole copy is then updated in one edge.
- R7: While the write bit (bit 7 of register 0) is 1, the copy is frozen but accepts bus writes. A write that clears the bit raises `load_valid` for exactly one cycle after that edge. In that cycle `load_time` carries the copy, byte i in bits 8i+7..8i.
- R8: When both control bits are set, the write bit wins. Clearing only the read bit keeps the copy frozen and produces no load. Clearing the write bit produces a load even while the read bit stays set.
- R9: Bit 7 of the day register (offset 4) ignores writes and always reads back the level of `batt_ok`.
- R10: Counter-owned bits per offset are 0:0x3F, 1:0x7F, 2:0x7F, 3:0x3F, 4:0x07, 5:0x3F, 6:0x1F, 7:0xFF. Other bits, except the two control bits and the battery flag, are plain storage that an update leaves alone.
- R11: After reset the copy and both control bits are zero, no update is pending, and `load_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus transfer in this cycle |
| bus_wr | input | 1 | Transfer is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (register or RAM) |
| ram_sel | output | 1 | RAM transfer request |
| ram_wr | output | 1 | RAM write |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| tick | input | 1 | One-second pulse from the counter |
| live_time | input | 64 | Current counter bytes |
| batt_ok | input | 1 | Battery health level |
| load_valid | output | 1 | One-cycle load strobe to the counter |
| load_time | output | 64 | Bytes to load into the counter |

## Verification
The bench builds the block with the default 11-bit address. At that width all 2048 addresses can be swept, so every RAM-versus-register decode boundary is checked exactly rather than sampled. The same small configuration lets the bench track all eight register bytes in a model. That model covers every freeze, resume, deferred-tick and load ordering with arithmetically predicted values.

// File: rtl/rtc_regwin_pkg.sv
package rtc_regwin_pkg;
    localparam int NREG     = 8;
    localparam int IDX_W    = $clog2(NREG);
    localparam int CTL_IX   = 0;
    localparam int DAY_IX   = 4;
    localparam int WR_BIT   = 7;
    localparam int RD_BIT   = 6;
    localparam int BATT_BIT = 7;

    // bits of each register driven by the calendar counter
    function automatic logic [7:0] cnt_mask(input int ix);
        case (ix)
            0:       return 8'h3F;
            1, 2:    return 8'h7F;
            3, 5:    return 8'h3F;
            4:       return 8'h07;
            6:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    typedef struct packed {
        logic [NREG-1:0][7:0] bytes;
    } copy_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic pend;
        logic load;
    } ctl_t;
endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec #(
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 3
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              ram_sel
);
    always_comb begin
        hit     = &bus_addr[ADDR_W-1:IDX_W];
        idx     = bus_addr[IDX_W-1:0];
        ram_sel = bus_sel && !hit;
    end
endmodule

// File: rtl/rtc_sync_ctl.sv
module rtc_sync_ctl
    import rtc_regwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_sel,
    input  logic ctl_we,
    input  logic rd_bit_in,
    input  logic wr_bit_in,
    input  logic tick,
    output logic rd_o,
    output logic wr_o,
    output logic refresh_o,
    output logic load_o
);
    ctl_t st_d, st_q;
    logic frozen;
    logic refresh;

    always_comb begin
        st_d    = st_q;
        st_d.load = 1'b0;
        frozen  = st_q.rd || st_q.wr;
        refresh = !frozen && (tick || st_q.pend) && !bus_sel;
        if (frozen) st_d.pend = 1'b0;
        else        st_d.pend = (tick || st_q.pend) && !refresh;
        if (ctl_we) begin
            st_d.rd   = rd_bit_in;
            st_d.wr   = wr_bit_in;
            st_d.load = st_q.wr && !wr_bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_o      = st_q.rd;
    assign wr_o      = st_q.wr;
    assign refresh_o = refresh;
    assign load_o    = st_q.load;

    // R4: no update while a bus transfer is in progress
    p_no_refresh_in_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> !bus_sel);
    // R3 / R5: updates only while unfrozen
    p_refresh_unfrozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> (!rd_o && !wr_o));
    // R7: clearing the write bit always yields a load
    p_load_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_o) |-> load_o);
    // R7: load strobe lasts one cycle
    p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
    import rtc_regwin_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ram_sel,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              tick,
    input  logic [NREG*8-1:0] live_time,
    input  logic              batt_ok,
    output logic              load_valid,
    output logic [NREG*8-1:0] load_time
);
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             ctl_rd, ctl_wr, refresh, load;
    logic             wr_hit;
    copy_t            copy_d, copy_q;
    logic [NREG-1:0][7:0] merged;

    rtc_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .hit     (hit),
        .idx     (idx),
        .ram_sel (ram_sel)
    );

    assign wr_hit = bus_sel && bus_wr && hit;

    rtc_sync_ctl ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .ctl_we   (wr_hit && (int'(idx) == CTL_IX)),
        .rd_bit_in(bus_wdata[RD_BIT]),
        .wr_bit_in(bus_wdata[WR_BIT]),
        .tick     (tick),
        .rd_o     (ctl_rd),
        .wr_o     (ctl_wr),
        .refresh_o(refresh),
        .load_o   (load)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_merge
        localparam logic [7:0] M = cnt_mask(g);
        assign merged[g] = (copy_q.bytes[g] & ~M) | (live_time[g*8 +: 8] & M);
    end

    always_comb begin
        copy_d = copy_q;
        if (refresh) copy_d.bytes = merged;
        if (wr_hit) begin
            copy_d.bytes[idx] = bus_wdata;
            if (int'(idx) == DAY_IX)
                copy_d.bytes[idx][BATT_BIT] = copy_q.bytes[idx][BATT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) copy_q <= '0;
        else        copy_q <= copy_d;
    end

    always_comb begin
        bus_rdata = ram_rdata;
        if (hit) begin
            bus_rdata = copy_q.bytes[idx];
            if (int'(idx) == CTL_IX) begin
                bus_rdata[WR_BIT] = ctl_wr;
                bus_rdata[RD_BIT] = ctl_rd;
            end
            if (int'(idx) == DAY_IX) bus_rdata[BATT_BIT] = batt_ok;
        end
    end

    assign ram_wr     = bus_wr;
    assign ram_addr   = bus_addr;
    assign ram_wdata  = bus_wdata;
    assign load_valid = load;
    assign load_time  = copy_q.bytes;

    // R5: a frozen copy changes only through bus writes
    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_rd || ctl_wr) && !(bus_sel && bus_wr)) |=> $stable(copy_q));
    // R9: battery flag storage is never written
    p_day_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && int'(idx) == DAY_IX) |=> $stable(copy_q.bytes[DAY_IX][BATT_BIT]));
    // R1: RAM request only during a transfer
    p_ram_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> !ram_sel);
endmodule

// File: tb/rtc_regwin_tb_top.sv
module rtc_regwin_tb_top;
    localparam int AW   = 11;
    localparam int BASE = (1 << AW) - 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        ram_sel, ram_wr;
    logic [AW-1:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic        tick = 1'b0;
    logic [63:0] live_time = '0;
    logic        batt_ok = 1'b1;
    logic        load_valid;
    logic [63:0] load_time;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_b [8];
    logic rd_b = 1'b0, wr_b = 1'b0;

    always #5 clk = ~clk;
    assign ram_rdata = ~bus_addr[7:0] ^ 8'h5A;

    rtc_regwin #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ram_sel(ram_sel), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .tick(tick),
        .live_time(live_time), .batt_ok(batt_ok), .load_valid(load_valid),
        .load_time(load_time)
    );

    function automatic logic [7:0] mask_of(input int i);
        logic [7:0] m [8] = '{8'h3F, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
        return m[i];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int i);
        logic [7:0] v = exp_b[i];
        if (i == 4) v[7] = batt_ok;
        return v;
    endfunction

    task automatic peek_all(input string req);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_addr = AW'(BASE + i);
            #1 check(req, {56'h0, bus_rdata}, {56'h0, exp_read(i)});
        end
    endtask

    task automatic do_write(input int i, input logic [7:0] d, input string req);
        logic exp_load;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(BASE + i); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        exp_load = 1'b0;
        if (i == 4) exp_b[4] = {exp_b[4][7], d[6:0]};
        else        exp_b[i] = d;
        if (i == 0) begin
            exp_load = wr_b && !d[7];
            rd_b = d[6]; wr_b = d[7];
        end
        check({req, " load strobe"}, {63'h0, load_valid}, {63'h0, exp_load});
        if (exp_load) begin
            logic [63:0] e;
            for (int k = 0; k < 8; k++) e[k*8 +: 8] = exp_b[k];
            check({req, " load data"}, load_time, e);
        end
    endtask

    task automatic model_refresh();
        if (!rd_b && !wr_b)
            for (int k = 0; k < 8; k++)
                exp_b[k] = (exp_b[k] & ~mask_of(k)) | (live_time[k*8 +: 8] & mask_of(k));
    endtask

    task automatic do_tick(input logic [63:0] lt);
        @(negedge clk);
        live_time = lt; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_refresh();
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) exp_b[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 load_valid", {63'h0, load_valid}, 64'h0);
        peek_all("R11 reset copy");

        // R1: full address sweep
        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
            #1;
            check("R1 ram_sel", {63'h0, ram_sel}, {63'h0, (a < BASE)});
            if (a < BASE) check("R1 ram data", {56'h0, bus_rdata}, {56'h0, ~a[7:0] ^ 8'h5A});
        end
        @(negedge clk); bus_sel = 1'b0;
        #1 check("R1 idle ram_sel", {63'h0, ram_sel}, 64'h0);

        // R3: unfrozen tick refresh
        do_tick(64'h2399_1231_0759_5934);
        peek_all("R3 refresh");

        // R2 / R10: write storage bits, then refresh keeps them
        for (int i = 1; i < 8; i++) do_write(i, 8'hFF, "R2 write");
        peek_all("R2 readback");
        do_tick(64'h1111_1111_1111_1111);
        peek_all("R10 storage bits kept");

        // R4: tick during a bus transfer is deferred
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(16);
        live_time = 64'h2412_2806_2345_5820; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = AW'(BASE + 1);
        #1 check("R4 no update during access", {56'h0, bus_rdata}, {56'h0, exp_read(1)});
        model_refresh();
        @(negedge clk);
        #1 check("R4 deferred update", {56'h0, bus_rdata}, {56'h0, exp_read(1)});
        peek_all("R4 all bytes");

        // R5: read bit freezes
        do_write(0, 8'h40, "R5 set read");
        do_tick(64'h0102_0304_0506_0714);
        peek_all("R5 frozen");

        // R6: clear read bit, no update before tick
        do_write(0, 8'h00, "R6 clear read");
        repeat (4) @(negedge clk);
        peek_all("R6 waits for tick");
        do_tick(64'h0102_0304_0506_0714);
        peek_all("R6 update on tick");

        // R7: write bit, load values, clear
        do_write(0, 8'h80, "R7 set write");
        do_write(1, 8'h45, "R7 seconds");
        do_write(2, 8'h30, "R7 minutes");
        do_write(7, 8'h26, "R7 year");
        do_tick(64'h9999_9999_9999_9999);
        peek_all("R7 frozen accepts writes");
        do_write(0, 8'h05, "R7 clear write");
        @(negedge clk);
        check("R7 strobe one cycle", {63'h0, load_valid}, 64'h0);

        // R8: both bits, write wins
        do_write(0, 8'hC0, "R8 set both");
        do_write(0, 8'h80, "R8 clear read only");
        do_tick(64'h0303_0303_0303_0303);
        peek_all("R8 still frozen");
        do_write(0, 8'h40, "R8 clear write with read set");
        do_tick(64'h0404_0404_0404_0404);
        peek_all("R8 read still holds");
        do_write(0, 8'h00, "R8 release");
        do_tick(64'h0505_0505_0505_0505);
        peek_all("R8 resumed");

        // R9: battery flag
        do_write(4, 8'h85, "R9 write day");
        peek_all("R9 flag high");
        do_write(4, 8'h7A, "R9 write day zero bit");
        batt_ok = 1'b0;
        peek_all("R9 flag low");
        batt_ok = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule